// File: doc/BRIEF.md
# Processor Decrementer Timer

This block holds a 32-bit down-counter that a processor core can load and read back. The counter steps down by one on every timebase tick and wraps from zero to all-ones. Bit 31 of the count acts as its sign. When the count runs out, or software loads a value that is already at or past expiry, the block raises an interrupt request toward the core.

Two interrupt behaviours are available, picked by a static mode pin. In edge mode the request is a sticky flag. A qualifying event sets it, and the core's acknowledge clears it. In level mode the request tracks the sign of what software last wrote, so acknowledge does not clear it and only a write of a non-negative value takes it down. In both modes a write of a value below three, or a tick that takes the count from 2, 1 or 0, raises the request at once. The count therefore never has to pass through zero unobserved.

Top module: `dec_timer`

## Requirements
- R1: After reset, `rd_data` reads 0xFFFFFFFF and `irq` is low.
- R2: On a clock with `tick_en` high and `wr_en` low, the count drops by one, and 0 wraps to 0xFFFFFFFF. With both low the count holds.
- R3: A write loads `wr_data` into the count on the next clock. It wins over a tick in the same cycle, and `rd_data` always shows the current count.
- R4: A tick that takes the count from 2, 1 or 0 (with no write in that cycle) sets `irq` on the following clock. A tick from 3 or above raises nothing.
- R5: A write of any value below 3 sets `irq` on the following clock, in either mode.
- R6: In edge mode (`mode_level`=0), a write with bit 31 set raises `irq` only if the count before the write had bit 31 clear. A write of a value of 3 or more over an already negative count raises nothing.
- R7: In level mode (`mode_level`=1), any write with bit 31 set raises `irq`, whatever the previous count was.
- R8: In level mode, a write of a value of 3 or more with bit 31 clear drops `irq` on the following clock.
- R9: In edge mode, `irq_ack` clears `irq` on the following clock. In level mode, `irq_ack` leaves `irq` unchanged.
- R10: In edge mode, a write of a non-negative value of 3 or more leaves a pending `irq` set.
- R11: In edge mode, when a raising event and `irq_ack` fall in the same cycle, `irq` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_level | input | 1 | Static mode: 0 selects edge (sticky), 1 selects level |
| tick_en | input | 1 | Timebase tick; decrement this cycle |
| wr_en | input | 1 | Load the count from `wr_data` |
| wr_data | input | 32 | Value to load |
| irq_ack | input | 1 | Interrupt delivered to the core |
| rd_data | output | 32 | Current count |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run down through the 3-to-2 and 2-to-1 steps, so the bench can tell the real expiry window from a plain decrement. It also runs down through the wrap from zero. Writes are tried as small values, as negative values over both positive and negative counts, and as large positive values. This separates the small-value rule, the edge-mode sign-transition rule and the level-mode sign rule from one another. Acknowledge is applied alone and together with a raising event in both modes. That exposes whether delivery-clearing is wrongly active in level mode and whether set wins over clear. Writes that coincide with ticks show whether the load takes priority over the decrement.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
  parameter int unsigned DEC_W     = 32;
  parameter int unsigned SMALL_LIM = 3;
  localparam int unsigned SIGN_BIT = DEC_W - 1;

  typedef logic [DEC_W-1:0] dec_word_t;

  typedef enum logic {
    IRQ_EDGE  = 1'b0,
    IRQ_LEVEL = 1'b1
  } irq_mode_e;

  // Value is within the immediate-expiry window.
  function automatic logic is_small(input dec_word_t v);
    return v < dec_word_t'(SMALL_LIM);
  endfunction

  function automatic logic sign_of(input dec_word_t v);
    return v[SIGN_BIT];
  endfunction

  // Next count: a load beats a tick, and the decrement wraps naturally.
  function automatic dec_word_t next_count(input dec_word_t cur, input logic we,
                                           input dec_word_t wd, input logic te);
    if (we)      return wd;
    else if (te) return cur - dec_word_t'(1);
    else         return cur;
  endfunction
endpackage

// File: rtl/dec_count_reg.sv
`timescale 1ns/1ps
module dec_count_reg
  import dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      wr_en,
  input  dec_word_t wr_data,
  output dec_word_t count
);
  localparam dec_word_t RESET_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= RESET_VAL;
    else        count <= next_count(count, wr_en, wr_data, tick_en);
  end
endmodule

// File: rtl/dec_event_gen.sv
`timescale 1ns/1ps
module dec_event_gen
  import dec_pkg::*;
(
  input  irq_mode_e mode,
  input  logic      tick_en,
  input  logic      wr_en,
  input  dec_word_t wr_data,
  input  dec_word_t count,
  output logic      evt_tick,
  output logic      evt_wr_small,
  output logic      evt_wr_sign,
  output logic      clr_wr
);
  logic sign_ok;

  // Decrement out of 2, 1 or 0; suppressed when a load wins the cycle.
  assign evt_tick     = tick_en && !wr_en && is_small(count);
  assign evt_wr_small = wr_en && is_small(wr_data);

  generate
    if (1) begin : g_sign
      always_comb begin
        if (mode == IRQ_LEVEL) sign_ok = 1'b1;
        else                   sign_ok = !sign_of(count);
      end
    end
  endgenerate

  assign evt_wr_sign = wr_en && sign_of(wr_data) && sign_ok;
  // Level mode: non-negative write (not small) withdraws the request.
  assign clr_wr = (mode == IRQ_LEVEL) && wr_en && !sign_of(wr_data) && !is_small(wr_data);
endmodule

// File: rtl/dec_irq_ctl.sv
`timescale 1ns/1ps
module dec_irq_ctl
  import dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      set_req,
  input  logic      clr_wr,
  input  logic      irq_ack,
  output logic      clr_req,
  output logic      pend
);
  // Delivery clears only in edge mode.
  assign clr_req = clr_wr || ((mode == IRQ_EDGE) && irq_ack);

  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
    else if (clr_req) pend <= 1'b0;
  end
endmodule

// File: rtl/dec_timer.sv
`timescale 1ns/1ps
module dec_timer
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_level,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [DEC_W-1:0] wr_data,
  input  logic             irq_ack,
  output logic [DEC_W-1:0] rd_data,
  output logic             irq
);
  irq_mode_e mode;
  dec_word_t count;
  logic evt_tick, evt_wr_small, evt_wr_sign, clr_wr, clr_req, set_req;

  assign mode = irq_mode_e'(mode_level);

  dec_count_reg u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .count(count)
  );

  dec_event_gen u_evt (
    .mode(mode), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .evt_tick(evt_tick), .evt_wr_small(evt_wr_small),
    .evt_wr_sign(evt_wr_sign), .clr_wr(clr_wr)
  );

  assign set_req = evt_tick || evt_wr_small || evt_wr_sign;

  dec_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .set_req(set_req),
    .clr_wr(clr_wr), .irq_ack(irq_ack), .clr_req(clr_req), .pend(irq)
  );

  assign rd_data = count;
endmodule

// File: rtl/dec_timer_chk.sv
`timescale 1ns/1ps
module dec_timer_chk
  import dec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_level,
  input logic             tick_en,
  input logic             wr_en,
  input logic [DEC_W-1:0] wr_data,
  input logic             irq_ack,
  input logic [DEC_W-1:0] rd_data,
  input logic             irq,
  input logic             evt_tick,
  input logic             set_req
);
  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !wr_en |=> rd_data == $past(rd_data) - DEC_W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !wr_en |=> $stable(rd_data));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
  // R4
  tick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tick |=> irq);
  // R5
  small_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_data < DEC_W'(SMALL_LIM)) |=> irq);
  // R7
  lvl_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_level && wr_en && wr_data[DEC_W-1] |=> irq);
  // R8
  lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_level && wr_en && !wr_data[DEC_W-1] && (wr_data >= DEC_W'(SMALL_LIM)) |=> !irq);
  // R9
  lvl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_level && irq && !wr_en |=> irq);
  // R9
  edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_level && irq_ack && !set_req |=> !irq);
  // R11
  edge_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_level && irq_ack && set_req |=> irq);
endmodule

bind dec_timer dec_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_level(mode_level), .tick_en(tick_en),
  .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack), .rd_data(rd_data),
  .irq(irq), .evt_tick(evt_tick), .set_req(set_req)
);

// File: tb/dec_timer_tb.sv
`timescale 1ns/1ps
module dec_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_level = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        irq_ack = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int tests = 0;
  int fails = 0;

  logic [31:0] q_cnt[$];
  logic        q_irq[$];
  string       q_tag[$];

  logic [31:0] m_cnt;
  logic        m_irq;

  always #10 clk = ~clk;

  dec_timer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_level(mode_level), .tick_en(tick_en),
    .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
    .rd_data(rd_data), .irq(irq)
  );

  // Driver: apply one cycle of stimulus and queue the predicted outcome.
  task automatic step(input logic te, input logic we, input logic [31:0] wd,
                      input logic ack, input string tag);
    logic raise, drop;
    @(negedge clk);
    tick_en = te; wr_en = we; wr_data = wd; irq_ack = ack;
    raise = 1'b0;
    if (we && wd <= 32'd2) raise = 1'b1;
    if (we && wd[31] && (mode_level || m_cnt[31] == 1'b0)) raise = 1'b1;
    if (!we && te && (m_cnt == 32'd0 || m_cnt == 32'd1 || m_cnt == 32'd2)) raise = 1'b1;
    if (mode_level) drop = we && !wd[31] && wd > 32'd2;
    else            drop = ack;
    if (raise)     m_irq = 1'b1;
    else if (drop) m_irq = 1'b0;
    if (we)      m_cnt = wd;
    else if (te) m_cnt = m_cnt + 32'hFFFF_FFFF;
    q_cnt.push_back(m_cnt);
    q_irq.push_back(m_irq);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    tick_en = 0; wr_en = 0; wr_data = '0; irq_ack = 0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 0; mode_level = lvl;
    @(posedge clk); #5;
    tests++;
    if (rd_data !== 32'hFFFF_FFFF || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: cnt=%h irq=%b exp cnt=ffffffff irq=0", rd_data, irq);
    end
    @(negedge clk);
    rst_n = 1;
    m_cnt = 32'hFFFF_FFFF; m_irq = 1'b0;
  endtask

  // Monitor: compare after each active edge.
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q_cnt.size() > 0) begin
        logic [31:0] ec; logic ei; string t;
        ec = q_cnt.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
        tests++;
        if (rd_data !== ec || irq !== ei) begin
          fails++;
          $display("FAIL %s: cnt=%h irq=%b exp cnt=%h irq=%b", t, rd_data, irq, ec, ei);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Edge mode
    do_reset(1'b0);
    step(1, 0, 0, 0, "R2 tick");
    step(0, 0, 0, 0, "R2 hold");
    step(1, 1, 32'd5, 0, "R3 write beats tick");
    step(1, 0, 0, 0, "R4 tick 5->4");
    step(1, 0, 0, 0, "R4 tick 4->3");
    step(1, 0, 0, 0, "R4 tick 3->2 silent");
    step(1, 0, 0, 0, "R4 tick 2->1 raises");
    step(0, 0, 0, 1, "R9 edge ack clears");
    step(1, 0, 0, 0, "R4 tick 1->0 raises");
    step(0, 0, 0, 1, "R9 edge ack");
    step(1, 0, 0, 0, "R2 R4 wrap 0->ffffffff");
    step(0, 0, 0, 1, "R9 edge ack");
    step(0, 1, 32'h8000_0000, 0, "R6 neg over neg silent");
    step(0, 1, 32'd10, 0, "R10 positive write");
    step(0, 1, 32'h8000_0000, 0, "R6 neg over pos raises");
    step(0, 1, 32'd100, 0, "R10 positive keeps pending");
    step(0, 0, 0, 1, "R9 edge ack");
    step(0, 1, 32'd2, 0, "R5 write 2");
    step(0, 0, 0, 1, "R9 edge ack");
    step(0, 1, 32'd0, 0, "R5 write 0");
    step(0, 1, 32'd1, 1, "R11 small write with ack");
    step(1, 0, 0, 1, "R11 tick 1->0 with ack");
    step(0, 0, 0, 1, "R9 edge ack");
    drain();
    // Level mode
    do_reset(1'b1);
    step(0, 1, 32'h8000_0000, 0, "R7 neg over neg raises");
    step(0, 0, 0, 1, "R9 level ack ignored");
    step(0, 1, 32'd50, 0, "R8 positive write clears");
    step(0, 1, 32'd1, 0, "R5 level write 1");
    step(0, 1, 32'd4, 0, "R8 clear");
    step(1, 0, 0, 0, "R4 tick 4->3");
    step(1, 0, 0, 0, "R4 tick 3->2 silent");
    step(1, 0, 0, 0, "R4 tick 2->1 raises");
    step(0, 0, 0, 1, "R9 level ack ignored");
    step(0, 1, 32'd9, 0, "R8 clear");
    step(1, 1, 32'd0, 0, "R3 write 0 beats tick");
    step(1, 0, 0, 0, "R2 level wrap");
    drain();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule